// File: doc/BRIEF.md
# Indexed Two-Bank Register Port for a Real-Time Clock

This block is the host-facing register front end of a real-time-clock style device. The host reaches it through two index/data port pairs. It first writes a register number to an index port. It then reads or writes that register through the matching data port. Port offsets 0 and 1 form the lower pair and reach the lower 128-byte bank. Offsets 2 and 3 form the upper pair and reach a separate 128-byte bank of general-purpose storage. To reach host address 128 or above, software selects the upper pair and uses the address minus 128.

The lower bank holds the register map:
- ten time and alarm bytes at locations 0 to 9;
- four control/status registers at locations 10 to 13;
- general-purpose battery-backed RAM at locations 14 to 127.

The block applies the access side effects. Reading the flag register clears the pending flags. The update-in-progress bit and the validity byte are read-only, and writes to the flag byte are dropped. The timekeeping logic next door sets flags through single-cycle strobes and updates the time bytes through its own write port. It also reads the configuration and time bytes on flat output buses. No timekeeping arithmetic is done here.

Host reads are handled by a three-state machine:
- IDLE: the block accepts a read or a write.
- FETCH: the selected byte is latched, and a flag-register read clears the flags.
- RESPOND: the read data is presented with a valid pulse.

The transitions are:
- IDLE to FETCH on an accepted read.
- FETCH to RESPOND unconditionally.
- RESPOND to IDLE unconditionally.

Writes complete in IDLE without leaving it.

Top module: `rtcp_port`

## Requirements
- R1: `io_port` selects the access target: 0 is the lower index, 1 the lower data, 2 the upper index, 3 the upper data. An index write stores only the low 7 bits (bit 7 is dropped), and reading an index port returns `{1'b0, index}`.
- R2: An index keeps its value across any number of data accesses, so repeated data reads return the same location without rewriting the index.
- R3: A read strobe accepted in IDLE makes `io_rd_valid` high and `io_rdata` valid for exactly the cycle after the next rising edge. `io_ready` is low in FETCH and RESPOND, and any strobe given then is ignored. If read and write are given together in IDLE, the read wins and the write is dropped.
- R4: Lower locations 0 to 9 (time bytes) and 14 to 127 (RAM) read back what was written. Time byte i appears on `time_flat[8*i+7:8*i]`.
- R5: The upper bank is a separate 128-byte store: writing upper location n leaves lower location n unchanged.
- R6: Register A (location 10) stores bits 6:0 and drives them on `cfg_a`. Its bit 7 reads the `tk_uip` input, and writes to bit 7 are ignored.
- R7: Register B (location 11) stores all 8 bits and drives them on `cfg_b`. Bits 6, 5 and 4 are the enables for the periodic, alarm and update flags.
- R8: Register C (location 12) bits 6, 5 and 4 are set by one-cycle pulses on `tk_set_pf`, `tk_set_af` and `tk_set_uf`, and bits 3:0 read 0. Bit 7 reads 1 whenever a flag among bits 6:4 is set together with its enable at the same position in register B.
- R9: Reading register C returns the flags as they were and clears bits 6:4. A set pulse that arrives in the clearing cycle survives.
- R10: `irq` equals register C bit 7. After a read of register C it is low in the cycle `io_rd_valid` is high.
- R11: Host writes to register C and register D change nothing.
- R12: Register D (location 13) reads `{tk_vrt, 7'b0}`.
- R13: `tk_we` writes `tk_wdata` to time byte `tk_waddr` when the address is below 10. If the host writes the same byte in the same cycle, the host value wins.
- R14: After reset, every stored byte and both indexes are zero, `io_ready` is 1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_port | input | 2 | Port offset: 0/1 lower index/data, 2/3 upper index/data |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, valid with io_rd_valid |
| io_rd_valid | output | 1 | One-cycle read data valid |
| io_ready | output | 1 | High in IDLE, when a strobe is accepted |
| tk_we | input | 1 | Timekeeping write to a time byte |
| tk_waddr | input | 4 | Time byte number for tk_we |
| tk_wdata | input | 8 | Timekeeping write data |
| tk_uip | input | 1 | Update in progress, shown in register A bit 7 |
| tk_set_pf | input | 1 | Set periodic flag pulse |
| tk_set_af | input | 1 | Set alarm flag pulse |
| tk_set_uf | input | 1 | Set update flag pulse |
| tk_vrt | input | 1 | Valid RAM and time, shown in register D bit 7 |
| irq | output | 1 | Interrupt, equal to register C bit 7 |
| cfg_a | output | 7 | Register A stored bits 6:0 |
| cfg_b | output | 8 | Register B |
| time_flat | output | 80 | Time bytes 0 to 9, byte i at bits 8i+7:8i |

## Verification
Writes and timekeeping strobes take effect at the rising edge that samples them, so the bench looks at the ports at the following falling edge. Read data comes two edges after the read strobe: one edge enters FETCH and the next latches the data. The bench therefore holds the strobe for one edge and samples `io_rdata`, `io_rd_valid` and `irq` at the falling edge after the second rising edge. At the earlier falling edge, in FETCH, it checks that `io_ready` is low and that valid has not yet risen. The clear-race case places a flag pulse exactly in the FETCH cycle, and a host write is likewise placed there to show that a busy-time write is dropped.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FETCH   = 2'd1,
        ST_RESPOND = 2'd2
    } rtcp_state_e;

    localparam int DATA_W     = 8;
    localparam int BANK_DEPTH = 128;
    localparam int TIME_REGS  = 10;
    localparam int LOC_REG_A  = 10;
    localparam int LOC_REG_B  = 11;
    localparam int LOC_REG_C  = 12;
    localparam int LOC_REG_D  = 13;
    localparam int FIRST_RAM  = 14;

    localparam logic [1:0] PORT_IDX_LO  = 2'd0;
    localparam logic [1:0] PORT_DATA_LO = 2'd1;
    localparam logic [1:0] PORT_IDX_HI  = 2'd2;
    localparam logic [1:0] PORT_DATA_HI = 2'd3;

endpackage

// File: rtl/rtcp_ctrl.sv
module rtcp_ctrl
    import rtcp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_rd,
    input  logic       io_wr,
    input  logic [1:0] io_port,
    output logic [1:0] port_q,
    output logic       host_wr,
    output logic       fetch,
    output logic       rd_valid,
    output logic       ready
);

    rtcp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (io_rd) state_d = ST_FETCH;
            ST_FETCH:   state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            port_q  <= PORT_IDX_LO;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && io_rd) port_q <= io_port;
        end
    end

    always_comb begin
        ready    = (state_q == ST_IDLE);
        fetch    = (state_q == ST_FETCH);
        rd_valid = (state_q == ST_RESPOND);
        host_wr  = ready && io_wr && !io_rd;
    end

    // R3
    fetch_to_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> rd_valid);

    // R3
    valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> ready);

endmodule

// File: rtl/rtcp_index.sv
module rtcp_index #(
    parameter int IDX_W = 7,
    parameter int NBANK = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             port,
    input  logic [IDX_W-1:0]       wdata,
    output logic [NBANK*IDX_W-1:0] idx_flat
);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [IDX_W-1:0] idx_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             idx_q <= '0;
            else if (wr_en && port == 2'(2 * b))    idx_q <= wdata;
        end
        assign idx_flat[b*IDX_W +: IDX_W] = idx_q;
    end

    // R2
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(idx_flat));

endmodule

// File: rtl/rtcp_lower.sv
module rtcp_lower
    import rtcp_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int NTIME = TIME_REGS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   host_we,
    input  logic [DATA_W-1:0]      host_wdata,
    input  logic                   clr_c,
    input  logic                   tk_we,
    input  logic [$clog2(NTIME)-1:0] tk_waddr,
    input  logic [DATA_W-1:0]      tk_wdata,
    input  logic                   tk_uip,
    input  logic                   tk_set_pf,
    input  logic                   tk_set_af,
    input  logic                   tk_set_uf,
    input  logic                   tk_vrt,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   irq,
    output logic [DATA_W-2:0]      cfg_a,
    output logic [DATA_W-1:0]      cfg_b,
    output logic [NTIME*DATA_W-1:0] time_flat
);

    localparam int TW        = $clog2(NTIME);
    localparam int RAM_DEPTH = (1 << IDX_W) - FIRST_RAM;

    logic [DATA_W-1:0] time_q [NTIME];
    logic [DATA_W-2:0] a_q;
    logic [DATA_W-1:0] b_q;
    logic [2:0]        flags_q;
    logic [DATA_W-1:0] ram_q [RAM_DEPTH];
    logic [2:0]        set_v;
    logic [IDX_W-1:0]  ram_off;

    assign set_v   = {tk_set_pf, tk_set_af, tk_set_uf};
    assign ram_off = idx - IDX_W'(FIRST_RAM);

    for (genvar i = 0; i < NTIME; i++) begin : g_time
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                time_q[i] <= '0;
            else if (host_we && idx == IDX_W'(i))
                time_q[i] <= host_wdata;
            else if (tk_we && tk_waddr == TW'(i))
                time_q[i] <= tk_wdata;
        end
        assign time_flat[i*DATA_W +: DATA_W] = time_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            flags_q <= '0;
        end else begin
            if (host_we && idx == IDX_W'(LOC_REG_A)) a_q <= host_wdata[DATA_W-2:0];
            if (host_we && idx == IDX_W'(LOC_REG_B)) b_q <= host_wdata;
            flags_q <= set_v | (flags_q & {3{~clr_c}});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < RAM_DEPTH; k++) ram_q[k] <= '0;
        end else if (host_we && idx >= IDX_W'(FIRST_RAM)) begin
            ram_q[ram_off] <= host_wdata;
        end
    end

    assign irq   = |(flags_q & b_q[6:4]);
    assign cfg_a = a_q;
    assign cfg_b = b_q;

    always_comb begin
        rd_data = '0;
        if (idx < IDX_W'(NTIME))             rd_data = time_q[idx[TW-1:0]];
        else if (idx == IDX_W'(LOC_REG_A))   rd_data = {tk_uip, a_q};
        else if (idx == IDX_W'(LOC_REG_B))   rd_data = b_q;
        else if (idx == IDX_W'(LOC_REG_C))   rd_data = {irq, flags_q, 4'b0000};
        else if (idx == IDX_W'(LOC_REG_D))   rd_data = {tk_vrt, 7'b0000000};
        else                                 rd_data = ram_q[ram_off];
    end

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_c && set_v == 3'b000) |=> (flags_q == 3'b000));

    // R10
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_c && set_v == 3'b000) |=> !irq);

    // R11
    flag_wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && idx == IDX_W'(LOC_REG_C) && !clr_c && set_v == 3'b000)
        |=> $stable(flags_q));

endmodule

// File: rtl/rtcp_upper.sv
module rtcp_upper
    import rtcp_pkg::*;
#(
    parameter int DEPTH = BANK_DEPTH,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    assign rd_data = mem_q[idx];

    // R5
    upper_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (!$stable(idx) || rd_data == $past(wdata)));

endmodule

// File: rtl/rtcp_port.sv
module rtcp_port
    import rtcp_pkg::*;
#(
    parameter int NTIME = TIME_REGS,
    parameter int DEPTH = BANK_DEPTH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              io_port,
    input  logic                    io_wr,
    input  logic                    io_rd,
    input  logic [7:0]              io_wdata,
    output logic [7:0]              io_rdata,
    output logic                    io_rd_valid,
    output logic                    io_ready,
    input  logic                    tk_we,
    input  logic [$clog2(NTIME)-1:0] tk_waddr,
    input  logic [7:0]              tk_wdata,
    input  logic                    tk_uip,
    input  logic                    tk_set_pf,
    input  logic                    tk_set_af,
    input  logic                    tk_set_uf,
    input  logic                    tk_vrt,
    output logic                    irq,
    output logic [6:0]              cfg_a,
    output logic [7:0]              cfg_b,
    output logic [NTIME*8-1:0]      time_flat
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int NBANK = 2;

    logic [1:0]             port_q;
    logic                   host_wr, fetch;
    logic [NBANK*IDX_W-1:0] idx_flat;
    logic [IDX_W-1:0]       idx_lo, idx_hi;
    logic [7:0]             lo_rd, hi_rd, rdata_q, sel_rd;
    logic                   clr_c;

    rtcp_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_port  (io_port),
        .port_q   (port_q),
        .host_wr  (host_wr),
        .fetch    (fetch),
        .rd_valid (io_rd_valid),
        .ready    (io_ready)
    );

    rtcp_index #(.IDX_W(IDX_W), .NBANK(NBANK)) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr),
        .port     (io_port),
        .wdata    (io_wdata[IDX_W-1:0]),
        .idx_flat (idx_flat)
    );

    assign idx_lo = idx_flat[0 +: IDX_W];
    assign idx_hi = idx_flat[IDX_W +: IDX_W];
    assign clr_c  = fetch && port_q == PORT_DATA_LO && idx_lo == IDX_W'(LOC_REG_C);

    rtcp_lower #(.IDX_W(IDX_W), .NTIME(NTIME)) u_lower (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (idx_lo),
        .host_we    (host_wr && io_port == PORT_DATA_LO),
        .host_wdata (io_wdata),
        .clr_c      (clr_c),
        .tk_we      (tk_we),
        .tk_waddr   (tk_waddr),
        .tk_wdata   (tk_wdata),
        .tk_uip     (tk_uip),
        .tk_set_pf  (tk_set_pf),
        .tk_set_af  (tk_set_af),
        .tk_set_uf  (tk_set_uf),
        .tk_vrt     (tk_vrt),
        .rd_data    (lo_rd),
        .irq        (irq),
        .cfg_a      (cfg_a),
        .cfg_b      (cfg_b),
        .time_flat  (time_flat)
    );

    rtcp_upper #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_upper (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (idx_hi),
        .we      (host_wr && io_port == PORT_DATA_HI),
        .wdata   (io_wdata),
        .rd_data (hi_rd)
    );

    always_comb begin
        unique case (port_q)
            PORT_IDX_LO:  sel_rd = 8'(idx_lo);
            PORT_DATA_LO: sel_rd = lo_rd;
            PORT_IDX_HI:  sel_rd = 8'(idx_hi);
            default:      sel_rd = hi_rd;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (fetch) rdata_q <= sel_rd;
    end

    assign io_rdata = rdata_q;

    // R3
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_ready |=> (io_rd_valid || $stable(io_rdata)));

endmodule

// File: tb/rtcp_port_tb.sv
module rtcp_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  io_port = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rd_valid, io_ready;
    logic        tk_we = 1'b0;
    logic [3:0]  tk_waddr = '0;
    logic [7:0]  tk_wdata = '0;
    logic        tk_uip = 1'b0, tk_set_pf = 1'b0, tk_set_af = 1'b0, tk_set_uf = 1'b0;
    logic        tk_vrt = 1'b0;
    logic        irq;
    logic [6:0]  cfg_a;
    logic [7:0]  cfg_b;
    logic [79:0] time_flat;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    rtcp_port dut_i (
        .clk(clk), .rst_n(rst_n), .io_port(io_port), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rd_valid(io_rd_valid),
        .io_ready(io_ready), .tk_we(tk_we), .tk_waddr(tk_waddr), .tk_wdata(tk_wdata),
        .tk_uip(tk_uip), .tk_set_pf(tk_set_pf), .tk_set_af(tk_set_af),
        .tk_set_uf(tk_set_uf), .tk_vrt(tk_vrt), .irq(irq), .cfg_a(cfg_a),
        .cfg_b(cfg_b), .time_flat(time_flat)
    );

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] p, input logic [7:0] d);
        io_port = p; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] p, output logic [7:0] d);
        io_port = p; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        @(negedge clk);
        check("R3 valid", io_rd_valid, 1'b1);
        d = io_rdata;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [6:0] loc, input logic [7:0] d);
        host_write(2'd0, {1'b0, loc});
        host_write(2'd1, d);
    endtask

    task automatic reg_read(input logic [6:0] loc, output logic [7:0] d);
        host_write(2'd0, {1'b0, loc});
        host_read(2'd1, d);
    endtask

    task automatic pulse_flags(input logic pf, input logic af, input logic uf);
        tk_set_pf = pf; tk_set_af = af; tk_set_uf = uf;
        @(negedge clk);
        tk_set_pf = 1'b0; tk_set_af = 1'b0; tk_set_uf = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R14 ready", io_ready, 1'b1);
        check("R14 irq", irq, 1'b0);
        check("R14 cfg_b", cfg_b, 8'h00);
        host_read(2'd0, d); check("R14 index", d, 8'h00);
        host_read(2'd1, d); check("R14 loc0", d, 8'h00);
        host_read(2'd3, d); check("R14 upper0", d, 8'h00);
    endtask

    task automatic t_lower_map();
        logic [7:0] d;
        reg_write(7'd3, 8'h59);
        host_read(2'd1, d); check("R2 first read", d, 8'h59);
        host_read(2'd1, d); check("R2 second read", d, 8'h59);
        check("R4 time_flat byte3", time_flat[31:24], 8'h59);
        host_write(2'd0, 8'h8E);
        host_read(2'd0, d); check("R1 index bit7 dropped", d, 8'h0E);
        host_write(2'd1, 8'hC3);
        host_read(2'd1, d); check("R4 ram 14", d, 8'hC3);
        reg_write(7'd127, 8'h7E);
        reg_read(7'd127, d); check("R4 ram 127", d, 8'h7E);
    endtask

    task automatic t_upper_bank();
        logic [7:0] d;
        host_write(2'd2, 8'h85);
        host_write(2'd3, 8'hA5);
        host_read(2'd3, d); check("R5 upper data", d, 8'hA5);
        host_read(2'd2, d); check("R1 upper index", d, 8'h05);
        reg_read(7'd5, d); check("R5 lower loc5 untouched", d, 8'h00);
    endtask

    task automatic t_reg_a_b();
        logic [7:0] d;
        reg_write(7'd10, 8'hFF);
        host_read(2'd1, d); check("R6 uip low", d, 8'h7F);
        check("R6 cfg_a", cfg_a, 7'h7F);
        tk_uip = 1'b1;
        host_read(2'd1, d); check("R6 uip high", d, 8'hFF);
        tk_uip = 1'b0;
        reg_write(7'd11, 8'h5A);
        check("R7 cfg_b", cfg_b, 8'h5A);
        host_read(2'd1, d); check("R7 read B", d, 8'h5A);
        reg_write(7'd11, 8'h00);
    endtask

    task automatic t_flags();
        logic [7:0] d;
        pulse_flags(1'b0, 1'b1, 1'b0);
        check("R10 irq masked", irq, 1'b0);
        reg_read(7'd12, d); check("R8 alarm flag", d, 8'h20);
        host_read(2'd1, d); check("R9 cleared", d, 8'h00);
        reg_write(7'd11, 8'h20);
        pulse_flags(1'b0, 1'b1, 1'b0);
        check("R10 irq raised", irq, 1'b1);
        host_write(2'd0, 8'h0C);
        io_port = 2'd1; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        @(negedge clk);
        check("R8 summary bit", io_rdata, 8'hA0);
        check("R10 irq released", irq, 1'b0);
        @(negedge clk);
        pulse_flags(1'b1, 1'b0, 1'b1);
        reg_read(7'd12, d); check("R8 pf uf not enabled", d, 8'h50);
        check("R10 irq stays low", irq, 1'b0);
        reg_write(7'd11, 8'h00);
    endtask

    task automatic t_clear_race();
        logic [7:0] d;
        host_write(2'd0, 8'h0C);
        io_port = 2'd1; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        tk_set_pf = 1'b1;
        @(negedge clk);
        tk_set_pf = 1'b0;
        check("R9 race read data", io_rdata, 8'h00);
        @(negedge clk);
        host_read(2'd1, d); check("R9 set survives clear", d, 8'h40);
        host_read(2'd1, d); check("R9 cleared after", d, 8'h00);
    endtask

    task automatic t_ignored_writes();
        logic [7:0] d;
        pulse_flags(1'b0, 1'b1, 1'b0);
        reg_write(7'd12, 8'h00);
        host_read(2'd1, d); check("R11 write C ignored", d, 8'h20);
        tk_vrt = 1'b1;
        reg_write(7'd13, 8'h00);
        host_read(2'd1, d); check("R12 vrt high", d, 8'h80);
        host_write(2'd1, 8'h7F);
        host_read(2'd1, d); check("R11 write D ignored", d, 8'h80);
        tk_vrt = 1'b0;
        host_read(2'd1, d); check("R12 vrt low", d, 8'h00);
    endtask

    task automatic t_neighbour();
        logic [7:0] d;
        tk_we = 1'b1; tk_waddr = 4'd9; tk_wdata = 8'h24;
        @(negedge clk);
        tk_we = 1'b0;
        check("R13 time_flat byte9", time_flat[79:72], 8'h24);
        reg_read(7'd9, d); check("R13 read byte9", d, 8'h24);
        host_write(2'd0, 8'h02);
        io_port = 2'd1; io_wdata = 8'h11; io_wr = 1'b1;
        tk_we = 1'b1; tk_waddr = 4'd2; tk_wdata = 8'h22;
        @(negedge clk);
        io_wr = 1'b0; tk_we = 1'b0;
        host_read(2'd1, d); check("R13 host wins", d, 8'h11);
    endtask

    task automatic t_busy();
        logic [7:0] d;
        reg_write(7'd4, 8'h3C);
        io_port = 2'd1; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        check("R3 ready low in fetch", io_ready, 1'b0);
        check("R3 no early valid", io_rd_valid, 1'b0);
        io_port = 2'd0; io_wdata = 8'h09; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        check("R3 valid pulse", io_rd_valid, 1'b1);
        check("R3 read data", io_rdata, 8'h3C);
        @(negedge clk);
        check("R3 valid one cycle", io_rd_valid, 1'b0);
        host_read(2'd0, d); check("R3 busy write dropped", d, 8'h04);
        io_port = 2'd1; io_wdata = 8'h77; io_rd = 1'b1; io_wr = 1'b1;
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        host_read(2'd1, d); check("R3 read beats write", d, 8'h3C);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lower_map();
        t_upper_bank();
        t_reg_a_b();
        t_flags();
        t_clear_race();
        t_ignored_writes();
        t_neighbour();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule